// File: doc/BRIEF.md
# Multi-core local interrupt router

This block collects the interrupt lines of a four-core cluster and delivers them, per core, to a normal-priority output (IRQ) and a fast output (FIQ). Every core has its own level inputs: four timer lines, four mailbox-pending lines and one PMU line. One GPU interrupt is shared by all cores. Each per-core source has a pair of enable bits, one for IRQ and one for FIQ. The shared GPU line is instead steered by two core-number fields, so it reaches exactly one core as IRQ and one core as FIQ.

Software configures the block over a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. A live, read-only pending word for each core shows which enabled sources are active. The block also keeps a control word and a prescaler word. These two are only stored and read back. PMU enables cannot be written directly: they change only through a write-one-to-set address and a write-one-to-clear address.

The interrupt outputs and the pending words are combinational functions of the inputs and the stored configuration. A source edge therefore reaches a core in the same cycle. A configuration write takes effect right after the clock edge that captures it.

Top module: `lintr_router`

## Requirements
- R1: After synchronous reset, every register reads 0. With every source held high except the GPU line, no core drives IRQ or FIQ.
- R2: The control word (offset 0x00) and the prescaler (offset 0x08) store and read back all 32 bits. A prescaler value of 0x80000000 selects the 19.2 MHz setting and reads back unchanged.
- R3: The timer configuration of core n is at offset 0x40+4n and reads back bits [7:0]. Bit t (0..3) routes timer t of that core to IRQ. Bit t+4 routes it to FIQ.
- R4: The mailbox configuration of core n is at offset 0x50+4n. It uses the same bit layout as the timer configuration for mailboxes 0..3, and reads back bits [7:0].
- R5: A source enabled for both IRQ and FIQ drives only FIQ.
- R6: The GPU routing register (offset 0x0C) stores bits [3:0]. Bits [1:0] name the core that gets the GPU line as IRQ. Bits [3:2] name the core that gets it as FIQ. When both fields name the same core, that core receives FIQ only.
- R7: A write to offset 0x10 sets the PMU enable bits that are written as one. A write to 0x14 clears them. Bit n enables core n's PMU line to IRQ and bit n+4 enables it to FIQ. Reads of either address return the PMU enable state.
- R8: The pending word of core n at offset 0x60+4n has the following layout. Bits 0..3 are the timers and bits 4..7 are mailboxes 0..3. Bit 8 is GPU and bit 9 is PMU. A bit is 1 while the source is high and enabled for IRQ or FIQ on that core. Bits 10 and above read 0.
- R9: Writes to pending offsets change nothing. Reads and writes of unmapped offsets (for example 0x04 and 0x30) return 0 and change nothing.
- R10: An output follows a source change within the same cycle. It follows a configuration write right after the capturing clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| tmr_lvl | input | 16 | Timer levels, core c timer t at bit 4c+t |
| mbx_lvl | input | 16 | Mailbox-pending levels, core c mailbox m at bit 4c+m |
| gpu_lvl | input | 1 | Shared GPU interrupt level |
| pmu_lvl | input | 4 | PMU level per core |
| core_irq | output | 4 | IRQ output per core |
| core_fiq | output | 4 | FIQ output per core |

## Verification
The bench goes after these corner cases:
- A source enabled for both outputs must not also raise IRQ. A design without FIQ priority would assert both lines.
- GPU steering with both fields naming the same core must yield FIQ only. Upper write bits must be dropped. A decoder reading the wrong field would signal the wrong core.
- PMU set and clear must leave unwritten bits untouched. A plain-write implementation would wipe earlier enables.
- Pending bits must cover only enabled sources. Writes to pending and unmapped offsets must change nothing visible. A design that lets them through would show extra pending bits or altered configuration.

// File: rtl/lintr_pkg.sv
package lintr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int NSRC   = 4;              // timers / mailboxes per core
    localparam int CFG_W  = 2 * NSRC;       // IRQ half + FIQ half
    localparam int NROUTE = 2 * NSRC + 2;   // timers, mailboxes, GPU, PMU
    localparam int PEND_W = NROUTE + 2;     // plus two unused source slots
    localparam int PB_GPU = 2 * NSRC;
    localparam int PB_PMU = 2 * NSRC + 1;

    localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PRESC   = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_GPU     = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_PMU_SET = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_PMU_CLR = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_TMR     = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_MBX     = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_PEND    = 8'h60;

    // Enable pair: low half routes to IRQ, high half to FIQ.
    typedef struct packed {
        logic [NSRC-1:0] fiq;
        logic [NSRC-1:0] irq;
    } en_pair_t;

    typedef struct packed {
        logic fiq;
        logic irq;
    } line_t;

    function automatic logic [ADDR_W-1:0] core_slot(logic [ADDR_W-1:0] base, int core);
        return base + ADDR_W'(core * 4);
    endfunction

    // FIQ wins over IRQ for a source enabled on both.
    function automatic line_t steer(logic [NROUTE-1:0] src,
                                    logic [NROUTE-1:0] ien,
                                    logic [NROUTE-1:0] fen);
        line_t r;
        r.fiq = |(src & fen);
        r.irq = |(src & ien & ~fen);
        return r;
    endfunction

endpackage

// File: rtl/lintr_regs.sv
module lintr_regs
    import lintr_pkg::*;
#(
    parameter int NCORE  = 4,
    parameter int CORE_W = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic                               bus_wr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic [DATA_W-1:0]                  bus_rdata,
    input  logic [NCORE-1:0][PEND_W-1:0]       pend_i,
    output en_pair_t [NCORE-1:0]               tcfg_o,
    output en_pair_t [NCORE-1:0]               mcfg_o,
    output logic [CORE_W-1:0]                  gpu_irq_core_o,
    output logic [CORE_W-1:0]                  gpu_fiq_core_o,
    output logic [NCORE-1:0]                   pmu_irq_en_o,
    output logic [NCORE-1:0]                   pmu_fiq_en_o
);

    localparam int GPU_W = 2 * CORE_W;

    logic [DATA_W-1:0]     ctrl_q;
    logic [DATA_W-1:0]     presc_q;
    logic [GPU_W-1:0]      gpu_q;
    logic [CFG_W-1:0]      pmu_q;
    en_pair_t [NCORE-1:0]  tcfg_q;
    en_pair_t [NCORE-1:0]  mcfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            presc_q <= '0;
            gpu_q   <= '0;
            pmu_q   <= '0;
            tcfg_q  <= '0;
            mcfg_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFF_CTRL)    ctrl_q  <= bus_wdata;
            if (bus_addr == OFF_PRESC)   presc_q <= bus_wdata;
            if (bus_addr == OFF_GPU)     gpu_q   <= bus_wdata[GPU_W-1:0];
            if (bus_addr == OFF_PMU_SET) pmu_q   <= pmu_q | bus_wdata[CFG_W-1:0];
            if (bus_addr == OFF_PMU_CLR) pmu_q   <= pmu_q & ~bus_wdata[CFG_W-1:0];
            for (int c = 0; c < NCORE; c++) begin
                if (bus_addr == core_slot(OFF_TMR, c)) tcfg_q[c] <= en_pair_t'(bus_wdata[CFG_W-1:0]);
                if (bus_addr == core_slot(OFF_MBX, c)) mcfg_q[c] <= en_pair_t'(bus_wdata[CFG_W-1:0]);
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL:                 bus_rdata = ctrl_q;
            OFF_PRESC:                bus_rdata = presc_q;
            OFF_GPU:                  bus_rdata = DATA_W'(gpu_q);
            OFF_PMU_SET, OFF_PMU_CLR: bus_rdata = DATA_W'(pmu_q);
            default:                  bus_rdata = '0;
        endcase
        for (int c = 0; c < NCORE; c++) begin
            if (bus_addr == core_slot(OFF_TMR, c))  bus_rdata = DATA_W'(tcfg_q[c]);
            if (bus_addr == core_slot(OFF_MBX, c))  bus_rdata = DATA_W'(mcfg_q[c]);
            if (bus_addr == core_slot(OFF_PEND, c)) bus_rdata = DATA_W'(pend_i[c]);
        end
    end

    assign tcfg_o         = tcfg_q;
    assign mcfg_o         = mcfg_q;
    assign gpu_irq_core_o = gpu_q[CORE_W-1:0];
    assign gpu_fiq_core_o = gpu_q[GPU_W-1:CORE_W];
    assign pmu_irq_en_o   = pmu_q[NCORE-1:0];
    assign pmu_fiq_en_o   = pmu_q[NSRC+NCORE-1:NSRC];

    logic unused_ok;
    assign unused_ok = ^{ctrl_q[0], pmu_q};

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (tcfg_q == '0 && mcfg_q == '0 && pmu_q == '0 && gpu_q == '0)); // R1

    AST_PMU_SET_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PMU_SET)
        |=> ((pmu_q & $past(bus_wdata[CFG_W-1:0])) == $past(bus_wdata[CFG_W-1:0]))); // R7

    AST_PMU_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_PMU_CLR)
        |=> ((pmu_q & $past(bus_wdata[CFG_W-1:0])) == '0)); // R7

    AST_PEND_WRITE_INERT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr[ADDR_W-1:4] == OFF_PEND[ADDR_W-1:4])
        |=> $stable({ctrl_q, presc_q, gpu_q, pmu_q, tcfg_q, mcfg_q})); // R9

endmodule

// File: rtl/lintr_core_route.sv
module lintr_core_route
    import lintr_pkg::*;
(
    input  logic [NSRC-1:0]   tmr_i,
    input  logic [NSRC-1:0]   mbx_i,
    input  logic              gpu_i,
    input  logic              pmu_i,
    input  en_pair_t          tcfg_i,
    input  en_pair_t          mcfg_i,
    input  logic              gpu_to_irq_i,
    input  logic              gpu_to_fiq_i,
    input  logic              pmu_irq_en_i,
    input  logic              pmu_fiq_en_i,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [PEND_W-1:0] pend_o
);

    logic [NROUTE-1:0] src, ien, fen;
    line_t             lines;

    assign src = {pmu_i,        gpu_i,        mbx_i,      tmr_i};
    assign ien = {pmu_irq_en_i, gpu_to_irq_i, mcfg_i.irq, tcfg_i.irq};
    assign fen = {pmu_fiq_en_i, gpu_to_fiq_i, mcfg_i.fiq, tcfg_i.fiq};

    assign lines  = steer(src, ien, fen);
    assign irq_o  = lines.irq;
    assign fiq_o  = lines.fiq;
    assign pend_o = PEND_W'(src & (ien | fen));

endmodule

// File: rtl/lintr_router.sv
module lintr_router
    import lintr_pkg::*;
#(
    parameter int NCORE = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  bus_wr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [NCORE*NSRC-1:0] tmr_lvl,
    input  logic [NCORE*NSRC-1:0] mbx_lvl,
    input  logic                  gpu_lvl,
    input  logic [NCORE-1:0]      pmu_lvl,
    output logic [NCORE-1:0]      core_irq,
    output logic [NCORE-1:0]      core_fiq
);

    localparam int CORE_W = (NCORE > 1) ? $clog2(NCORE) : 1;

    en_pair_t [NCORE-1:0]          tcfg, mcfg;
    logic [CORE_W-1:0]             gpu_irq_core, gpu_fiq_core;
    logic [NCORE-1:0]              pmu_irq_en, pmu_fiq_en;
    logic [NCORE-1:0][PEND_W-1:0]  pend;
    logic [NCORE-1:0]              gpu_pend;

    lintr_regs #(.NCORE(NCORE), .CORE_W(CORE_W)) regs_i (
        .clk            (clk),
        .rst            (rst),
        .bus_addr       (bus_addr),
        .bus_wr         (bus_wr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .pend_i         (pend),
        .tcfg_o         (tcfg),
        .mcfg_o         (mcfg),
        .gpu_irq_core_o (gpu_irq_core),
        .gpu_fiq_core_o (gpu_fiq_core),
        .pmu_irq_en_o   (pmu_irq_en),
        .pmu_fiq_en_o   (pmu_fiq_en)
    );

    for (genvar g = 0; g < NCORE; g++) begin : g_core
        lintr_core_route route_i (
            .tmr_i        (tmr_lvl[g*NSRC +: NSRC]),
            .mbx_i        (mbx_lvl[g*NSRC +: NSRC]),
            .gpu_i        (gpu_lvl),
            .pmu_i        (pmu_lvl[g]),
            .tcfg_i       (tcfg[g]),
            .mcfg_i       (mcfg[g]),
            .gpu_to_irq_i (gpu_irq_core == CORE_W'(g)),
            .gpu_to_fiq_i (gpu_fiq_core == CORE_W'(g)),
            .pmu_irq_en_i (pmu_irq_en[g]),
            .pmu_fiq_en_i (pmu_fiq_en[g]),
            .irq_o        (core_irq[g]),
            .fiq_o        (core_fiq[g]),
            .pend_o       (pend[g])
        );
        assign gpu_pend[g] = pend[g][PB_GPU];

        AST_IRQ_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
            core_irq[g] |-> (pend[g] != '0)); // R8
        AST_FIQ_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
            core_fiq[g] |-> (pend[g] != '0)); // R8
        AST_NO_DUAL_LINE: assert property (@(posedge clk) disable iff (rst)
            (pend[g] == pend[g][PB_GPU:0] && !gpu_lvl && $onehot0(pend[g]))
            |-> !(core_irq[g] && core_fiq[g])); // R5
    end

    AST_GPU_SPREAD: assert property (@(posedge clk) disable iff (rst)
        gpu_lvl |-> ($countones(gpu_pend) >= 1 && $countones(gpu_pend) <= 2)); // R6

    AST_GPU_QUIET: assert property (@(posedge clk) disable iff (rst)
        !gpu_lvl |-> (gpu_pend == '0)); // R8

endmodule

// File: tb/lintr_router_tb.sv
module lintr_router_tb_top;
    import lintr_pkg::*;

    localparam int NC = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [15:0]       tmr_lvl = '0;
    logic [15:0]       mbx_lvl = '0;
    logic              gpu_lvl = 1'b0;
    logic [3:0]        pmu_lvl = '0;
    logic [3:0]        core_irq, core_fiq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk; // 50 MHz

    lintr_router #(.NCORE(NC)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_lvl(tmr_lvl),
        .mbx_lvl(mbx_lvl), .gpu_lvl(gpu_lvl), .pmu_lvl(pmu_lvl),
        .core_irq(core_irq), .core_fiq(core_fiq)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, $sformatf("read %h", a), bus_rdata, exp);
    endtask

    task automatic out_chk(string req, logic [3:0] irq_e, logic [3:0] fiq_e);
        #1;
        chk(req, "irq", 32'(core_irq), 32'(irq_e));
        chk(req, "fiq", 32'(core_fiq), 32'(fiq_e));
    endtask

    task automatic do_reset();
        @(negedge clk);
        tmr_lvl = '0; mbx_lvl = '0; gpu_lvl = 1'b0; pmu_lvl = '0;
        bus_wr = 1'b0; rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        rd_chk("R1", 8'h00, 0);
        rd_chk("R1", 8'h08, 0);
        rd_chk("R1", 8'h0C, 0);
        rd_chk("R1", 8'h10, 0);
        for (int c = 0; c < NC; c++) begin
            rd_chk("R1", 8'(8'h40 + 4*c), 0);
            rd_chk("R1", 8'(8'h50 + 4*c), 0);
        end
        @(negedge clk);
        tmr_lvl = '1; mbx_lvl = '1; pmu_lvl = '1;
        out_chk("R1", 4'b0000, 4'b0000);
    endtask

    task automatic t_ctrl_presc();
        do_reset();
        bus_write(8'h08, 32'h8000_0000);
        rd_chk("R2", 8'h08, 32'h8000_0000);
        bus_write(8'h00, 32'hDEAD_BEEF);
        rd_chk("R2", 8'h00, 32'hDEAD_BEEF);
        rd_chk("R2", 8'h08, 32'h8000_0000);
    endtask

    task automatic t_timer();
        do_reset();
        bus_write(8'h48, 32'hFFFF_FF05);         // core 2: timers 0,2 to IRQ
        rd_chk("R3", 8'h48, 32'h05);
        @(negedge clk); tmr_lvl[2*4+2] = 1'b1;
        out_chk("R3", 4'b0100, 4'b0000);
        rd_chk("R8", 8'h68, 32'h004);
        @(negedge clk); tmr_lvl[2*4+1] = 1'b1;   // not enabled
        rd_chk("R8", 8'h68, 32'h004);
        @(negedge clk); tmr_lvl[2*4+2] = 1'b0;
        out_chk("R3", 4'b0000, 4'b0000);
    endtask

    task automatic t_mailbox();
        do_reset();
        bus_write(8'h54, 32'h20);                // core 1: mailbox 1 to FIQ
        rd_chk("R4", 8'h54, 32'h20);
        @(negedge clk); mbx_lvl[1*4+1] = 1'b1; mbx_lvl[0] = 1'b1;
        out_chk("R4", 4'b0000, 4'b0010);
        rd_chk("R8", 8'h64, 32'h020);
        rd_chk("R8", 8'h60, 32'h000);
    endtask

    task automatic t_fiq_prio();
        do_reset();
        bus_write(8'h40, 32'h11);
        @(negedge clk); tmr_lvl[0] = 1'b1;
        out_chk("R5", 4'b0000, 4'b0001);
        bus_write(8'h40, 32'h01);
        out_chk("R10", 4'b0001, 4'b0000);       // effective right after the edge
    endtask

    task automatic t_gpu();
        do_reset();
        @(negedge clk); gpu_lvl = 1'b1;
        out_chk("R6", 4'b0000, 4'b0001);        // reset fields both name core 0
        bus_write(8'h0C, 32'h0000_000D);        // IRQ core 1, FIQ core 3
        out_chk("R6", 4'b0010, 4'b1000);
        rd_chk("R6", 8'h0C, 32'hD);
        rd_chk("R8", 8'h64, 32'h100);
        rd_chk("R8", 8'h6C, 32'h100);
        rd_chk("R8", 8'h60, 32'h000);
        bus_write(8'h0C, 32'hFFFF_FFFA);        // both fields core 2
        rd_chk("R6", 8'h0C, 32'hA);
        out_chk("R6", 4'b0000, 4'b0100);
    endtask

    task automatic t_pmu();
        do_reset();
        @(negedge clk); pmu_lvl = 4'b1111;
        bus_write(8'h10, 32'h21);                // core 0 IRQ, core 1 FIQ
        out_chk("R7", 4'b0001, 4'b0010);
        rd_chk("R7", 8'h10, 32'h21);
        rd_chk("R7", 8'h14, 32'h21);
        bus_write(8'h10, 32'h04);
        rd_chk("R7", 8'h10, 32'h25);
        bus_write(8'h14, 32'h01);
        rd_chk("R7", 8'h14, 32'h24);
        out_chk("R7", 4'b0100, 4'b0010);
        rd_chk("R8", 8'h68, 32'h200);
    endtask

    task automatic t_ignored();
        do_reset();
        bus_write(8'h44, 32'h03);
        bus_write(8'h60, 32'hFFFF_FFFF);
        bus_write(8'h64, 32'hFFFF_FFFF);
        rd_chk("R9", 8'h64, 32'h0);
        rd_chk("R9", 8'h44, 32'h03);
        bus_write(8'h04, 32'h1234_5678);
        bus_write(8'h30, 32'hFFFF_FFFF);
        rd_chk("R9", 8'h04, 32'h0);
        rd_chk("R9", 8'h30, 32'h0);
        rd_chk("R9", 8'h00, 32'h0);
        rd_chk("R9", 8'h10, 32'h0);
        @(negedge clk); tmr_lvl = '1; mbx_lvl = '1; pmu_lvl = '1;
        out_chk("R9", 4'b0010, 4'b0000);
        rd_chk("R8", 8'h64, 32'h003);
    endtask

    task automatic t_timing();
        do_reset();
        bus_write(8'h5C, 32'h80);                // core 3 mailbox 3 to FIQ
        @(negedge clk); mbx_lvl[3*4+3] = 1'b1;
        out_chk("R10", 4'b0000, 4'b1000);
        @(negedge clk); mbx_lvl[3*4+3] = 1'b0;
        out_chk("R10", 4'b0000, 4'b0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_ctrl_presc();
        t_timer();
        t_mailbox();
        t_fiq_prio();
        t_gpu();
        t_pmu();
        t_ignored();
        t_timing();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule